// File: doc/BRIEF.md
# Direction-Aware GPIO Port with Timer Override

This block is an 8-bit general-purpose I/O port on a simple synchronous register bus. Software sees three registers: a port-value register, a read-only pin-sense register and a direction register. Each pad is an input or an output according to its direction bit. When a pad is an output it drives the stored port value.

Raw pad inputs pass through a two-flop synchronizer. The port-value register read is chosen bit by bit. An output bit returns the stored latch, and an input bit returns the synchronized pad level. The pin-sense register always returns the synchronized pad level. Software can therefore compare the level it drives with the level actually on the pad, and so find an overloaded or shorted output.

A timer compare channel may claim any pad. A claimed pad is forced to drive the timer's compare level. Its stored direction bit is left as it was. The block gives the pad ring one drive-enable and one output-level signal per pin.

Top module: `gpio_tmr_port`

## Requirements
- R1: While reset is held and at the first cycle after release, the direction register, the port-value latch and the pin-sense value are all zero, and no pad is driven (pin_oe = 0).
- R2: The direction register sits at address 2. It is read and written at any time, and it keeps its value unless written there. A direction bit of 1 makes the pad an output (pin_oe bit high), and 0 makes it an input.
- R3: A read of the port-value register at address 0 returns, for each bit, the stored latch bit when that bit's direction bit is 1, and the synchronized pad bit when it is 0.
- R4: A read of the pin-sense register at address 1 returns the synchronized pad level in every bit, whatever the direction setting.
- R5: A write to address 1 has no effect. The direction register and the port-value latch keep their values.
- R6: A change on pin_in appears in reads exactly two rising clock edges later. It is not visible after only one edge.
- R7: A set bit of tmr_ovr_en forces that pad's pin_oe high. The stored direction bit is unchanged and reads back as written.
- R8: On a pad whose tmr_ovr_en bit is set, pin_out carries the matching tmr_ovr_val bit instead of the port-value latch bit.
- R9: A write to address 0 updates the port-value latch even while the pads are inputs. Once a pad is switched to output, the stored value appears on pin_out and in port-value reads. The latch keeps its value unless written there.
- R10: bus_rdata is combinational in the cycle of the read strobe. It is zero while bus_rd is low, and it is zero for a read of the unused address 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Register select: 0 port value, 1 pin sense, 2 direction, 3 unused |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as bus_rd |
| pin_in | input | 8 | Raw pad input levels |
| tmr_ovr_en | input | 8 | Per-pin timer compare claim |
| tmr_ovr_val | input | 8 | Per-pin timer compare output level |
| pin_oe | output | 8 | Per-pin drive enable |
| pin_out | output | 8 | Per-pin output level |

## Verification
The bench uses the default port width of 8 and the 2-bit address space. With those values the tests can set up directions of mixed polarity, so one port-value read returns latch bits and pad bits side by side. The same settings also allow a timer claim on only the outer pins, which shows a forced pad next to one that follows its direction bit. The bench also counts synchronizer edges one by one, both right after reset release and while the direction is being changed.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/100ps
package gpio_port_pkg;
    localparam int PORT_W = 8;
    localparam int ADDR_W = 2;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_VALUE = 2'd0,
        SEL_SENSE = 2'd1,
        SEL_DIR   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic wr_value;
        logic wr_dir;
        logic wr_sense;
    } wr_strobe_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        return reg_sel_e'(a);
    endfunction

    function automatic wr_strobe_t make_strobes(input logic wr, input reg_sel_e s);
        wr_strobe_t st;
        st.wr_value = wr && (s == SEL_VALUE);
        st.wr_dir   = wr && (s == SEL_DIR);
        st.wr_sense = wr && (s == SEL_SENSE);
        return st;
    endfunction
endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/100ps
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_raw,
    output logic [W-1:0] pin_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;
    logic [1:0]   warm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= pin_raw;
            stage2_q <= stage1_q;
        end
    end

    // edges seen since reset release, saturating; used only by the checks
    always_ff @(posedge clk) begin
        if (rst)                 warm_q <= 2'd0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    assign pin_sync = stage2_q;

    AST_SYNC_RESET: assert property (@(posedge clk) rst |=> (pin_sync == '0)); // R1
    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2) |-> (pin_sync == $past(pin_raw, 2))); // R6
endmodule

// File: rtl/gpio_port_regs.sv
`timescale 1ns/100ps
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  wr_strobe_t   strobe,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value_q,
    output logic [W-1:0] dir_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
            dir_q   <= '0;
        end else begin
            if (strobe.wr_value) value_q <= wdata;
            if (strobe.wr_dir)   dir_q   <= wdata;
        end
    end

    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !strobe.wr_dir |=> $stable(dir_q)); // R2
    AST_VALUE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !strobe.wr_value |=> $stable(value_q)); // R9
    AST_SENSE_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        strobe.wr_sense |=> ($stable(value_q) && $stable(dir_q))); // R5
endmodule

// File: rtl/gpio_pad_mux.sv
`timescale 1ns/100ps
module gpio_pad_mux #(
    parameter int W = 8
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] value,
    input  logic [W-1:0] ovr_en,
    input  logic [W-1:0] ovr_val,
    output logic [W-1:0] oe,
    output logic [W-1:0] out
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        always_comb begin
            if (ovr_en[i]) begin
                oe[i]  = 1'b1;
                out[i] = ovr_val[i];
            end else begin
                oe[i]  = dir[i];
                out[i] = value[i];
            end
        end
    end
endmodule

// File: rtl/gpio_tmr_port.sv
`timescale 1ns/100ps
module gpio_tmr_port
    import gpio_port_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_in,
    input  logic [W-1:0]      tmr_ovr_en,
    input  logic [W-1:0]      tmr_ovr_val,
    output logic [W-1:0]      pin_oe,
    output logic [W-1:0]      pin_out
);
    reg_sel_e     sel;
    wr_strobe_t   strobe;
    logic [W-1:0] pin_sync;
    logic [W-1:0] value_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] value_view;

    assign sel    = decode_sel(bus_addr);
    assign strobe = make_strobes(bus_wr, sel);

    gpio_in_sync #(.W(W)) i_sync (
        .clk(clk), .rst(rst), .pin_raw(pin_in), .pin_sync(pin_sync)
    );

    gpio_port_regs #(.W(W)) i_regs (
        .clk(clk), .rst(rst), .strobe(strobe), .wdata(bus_wdata),
        .value_q(value_q), .dir_q(dir_q)
    );

    gpio_pad_mux #(.W(W)) i_mux (
        .dir(dir_q), .value(value_q), .ovr_en(tmr_ovr_en),
        .ovr_val(tmr_ovr_val), .oe(pin_oe), .out(pin_out)
    );

    // per-bit view of the port-value register: latch for outputs, pad for inputs
    for (genvar i = 0; i < W; i++) begin : g_view
        assign value_view[i] = dir_q[i] ? value_q[i] : pin_sync[i];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                SEL_VALUE: bus_rdata = value_view;
                SEL_SENSE: bus_rdata = pin_sync;
                SEL_DIR:   bus_rdata = dir_q;
                SEL_NONE:  bus_rdata = '0;
            endcase
        end
    end

    AST_OVR_KEEPS_DIR: assert property (@(posedge clk) disable iff (rst)
        ((|tmr_ovr_en) && !strobe.wr_dir) |=> $stable(dir_q)); // R7
    AST_PAD_SILENT_AFTER_RESET: assert property (@(posedge clk)
        (rst && $past(rst) && (tmr_ovr_en == '0)) |-> (pin_oe == '0)); // R1
endmodule

// File: tb/test_gpio_tmr_port.sv
`timescale 1ns/100ps
module test_gpio_tmr_port;
    localparam int W = 8;

    typedef struct {
        int        kind;   // 0 read data, 1 drive enable, 2 output level
        logic [7:0] exp;
        string     tag;
    } item_t;

    logic clk = 0;
    logic rst = 1;
    logic [1:0] bus_addr = 0;
    logic bus_wr = 0, bus_rd = 0;
    logic [W-1:0] bus_wdata = 0, pin_in = 0, tmr_ovr_en = 0, tmr_ovr_val = 0;
    logic [W-1:0] bus_rdata, pin_oe, pin_out;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    item_t sbq[$];

    always #2 clk = ~clk;

    gpio_tmr_port i_gpio_tmr_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .tmr_ovr_en(tmr_ovr_en), .tmr_ovr_val(tmr_ovr_val),
        .pin_oe(pin_oe), .pin_out(pin_out)
    );

    // monitor: pops expectations and compares them with the live outputs
    initial begin
        forever begin
            wait (sbq.size() > 0);
            begin
                item_t it;
                logic [7:0] act;
                it = sbq.pop_front();
                act = (it.kind == 0) ? bus_rdata : (it.kind == 1) ? pin_oe : pin_out;
                n_tests++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic next_cycle();
        @(negedge clk);
        bus_wr = 0;
        bus_rd = 0;
    endtask

    task automatic expect_item(input int kind, input logic [7:0] exp, input string tag);
        item_t it;
        #0.5;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
        wait (sbq.size() == 0);
    endtask

    task automatic read_now(input logic [1:0] a, input logic [7:0] exp, input string tag);
        bus_rd = 1;
        bus_addr = a;
        expect_item(0, exp, tag);
    endtask

    task automatic read_reg(input logic [1:0] a, input logic [7:0] exp, input string tag);
        next_cycle();
        read_now(a, exp, tag);
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        next_cycle();
        bus_wr = 1;
        bus_addr = a;
        bus_wdata = d;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        pin_in = 8'hA5;
        // R1: state right after release
        read_now(2'd1, 8'h00, "R1");
        read_now(2'd2, 8'h00, "R1");
        read_now(2'd0, 8'h00, "R1");
        expect_item(1, 8'h00, "R1");
        // R6: one edge is not enough, two edges are
        read_reg(2'd1, 8'h00, "R6");
        read_reg(2'd1, 8'hA5, "R6");
        // R2: direction write and readback, drive enables follow
        write_reg(2'd2, 8'h0F);
        read_reg(2'd2, 8'h0F, "R2");
        expect_item(1, 8'h0F, "R2");
        // R3: mixed read of the port-value register
        write_reg(2'd0, 8'h3C);
        read_reg(2'd0, 8'hAC, "R3");
        expect_item(2, 8'h3C, "R3");
        // R4: sense register is independent of direction
        read_reg(2'd1, 8'hA5, "R4");
        // R5: write to sense address is dropped
        write_reg(2'd1, 8'hFF);
        read_reg(2'd2, 8'h0F, "R5");
        read_reg(2'd0, 8'hAC, "R5");
        read_reg(2'd1, 8'hA5, "R5");
        // R9: value written while input shows up once output
        write_reg(2'd2, 8'h00);
        write_reg(2'd0, 8'h96);
        read_reg(2'd0, 8'hA5, "R9");
        write_reg(2'd2, 8'hFF);
        read_reg(2'd0, 8'h96, "R9");
        expect_item(2, 8'h96, "R9");
        expect_item(1, 8'hFF, "R9");
        // R6: pad change during direction switch to input
        write_reg(2'd2, 8'h00);
        pin_in = 8'h5A;
        read_reg(2'd0, 8'hA5, "R6");
        read_reg(2'd0, 8'h5A, "R6");
        // R7/R8: timer claims the outer pins
        next_cycle();
        tmr_ovr_en = 8'h81;
        tmr_ovr_val = 8'h80;
        expect_item(1, 8'h81, "R7");
        expect_item(2, 8'h96 & 8'h7E | 8'h80, "R8");
        read_reg(2'd2, 8'h00, "R7");
        tmr_ovr_val = 8'h01;
        expect_item(2, 8'h96 & 8'h7E | 8'h01, "R8");
        tmr_ovr_en = 8'h00;
        expect_item(1, 8'h00, "R7");
        // R10: idle strobe and unused address
        next_cycle();
        bus_addr = 2'd2;
        expect_item(0, 8'h00, "R10");
        read_reg(2'd3, 8'h00, "R10");
        // R1: reset again clears everything
        next_cycle();
        rst = 1;
        repeat (2) next_cycle();
        expect_item(1, 8'h00, "R1");
        rst = 0;
        read_now(2'd2, 8'h00, "R1");
        read_now(2'd1, 8'h00, "R1");
        next_cycle();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule